// File: doc/BRIEF.md
# Command Byte Queue with Fill-Level Interrupts

This block holds command and payload bytes on their way from a byte-wide serial receiver to a modulator that consumes them one at a time. The receiver pushes bytes whenever it has them. The consumer pulls the oldest byte on request, even while pushes are still arriving. Because the bytes leave in arrival order with no gaps, one data stream can be split across several commands. Storage is sixteen 8-bit entries, which is 128 bits.

A small zone state machine follows the fill level through four states. `Z_EMPTY` means 0 bytes, `Z_LOW` means 1 to 3 bytes, `Z_MID` means 4 to 15 bytes and `Z_FULL` means 16 bytes. The level moves by at most one per cycle, so the zone transitions are:

- `Z_EMPTY` and `Z_LOW` go to each other.
- `Z_LOW` and `Z_MID` go to each other.
- `Z_MID` and `Z_FULL` go to each other.
- Wake-up takes any state back to `Z_EMPTY`.

Only the `Z_MID` to `Z_LOW` transition latches the low-watermark flag, which asks the controller to refill the queue. A push that finds the queue full, with no pop in the same cycle, is dropped and latches a sticky overflow flag. The interrupt line is the OR of the two flags, and each flag has its own clear input. A wake-up pulse from power-down empties the queue.

Top module: `cmdbuf_fifo`

## Requirements
- R1: After reset, `buf_empty`=1, `buf_full`=0, `fill_level`=0, `irq`=0, both flags are 0 and `rd_data`=0.
- R2: Bytes appear on `rd_data` in the order they were accepted. `rd_data` changes to the oldest byte on the clock edge that accepts a pop (`rd_en` high while the queue is not empty).
- R3: `fill_level` counts the stored bytes from 0 to 16. `buf_empty` is 1 exactly when the level is 0, and `buf_full` is 1 exactly when the level is 16.
- R4: A push and an accepted pop in the same cycle leave the level unchanged. This also holds when the queue is full, and in that case the push is stored and no overflow is flagged.
- R5: A push while full without a pop is discarded. The level and the stored bytes stay unchanged, and `ovf_flag` goes to 1 and stays there until it is cleared.
- R6: `low_flag` sets only when a pop takes the level from 4 to 3. It does not set again while the level stays below 4.
- R7: A pop request while the queue is empty is ignored. The level stays 0 and `rd_data` keeps its previous value.
- R8: `irq` equals `low_flag` OR `ovf_flag`. `clr_low` clears only `low_flag` and `clr_ovf` clears only `ovf_flag`. A new event in the same cycle as its clear wins, so the flag stays set.
- R9: `wake` is synchronous and overrides every other input. On the next edge the level is 0, the queue is empty, both flags are 0, and the next push is stored at the head again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wake | input | 1 | Wake-up from power-down: empties the queue |
| wr_en | input | 1 | Push request from the serial receiver |
| wr_data | input | 8 | Byte to push |
| rd_en | input | 1 | Pop request from the modulator |
| rd_data | output | 8 | Most recently popped byte |
| fill_level | output | 5 | Number of stored bytes, 0 to 16 |
| buf_empty | output | 1 | Level is 0 |
| buf_full | output | 1 | Level is 16 |
| clr_low | input | 1 | Clears the low-watermark flag |
| clr_ovf | input | 1 | Clears the overflow flag |
| low_flag | output | 1 | Latched low-watermark event |
| ovf_flag | output | 1 | Latched overflow event |
| irq | output | 1 | Interrupt request, the OR of both flags |

## Verification
The queue is driven with three kinds of traffic:

- **Pushes only.** Shows whether the count and the write side advance alone.
- **Pops only.** Shows whether draining crosses the watermark exactly once.
- **Push and pop in the same cycle.** Shows whether the level holds while the data still moves through in order. This is tried both in the middle of the range and at the full boundary.

Pops on an empty queue and pushes on a full queue tell apart an ignored request from one that was wrongly accepted. For the overflow case, the dropped byte must be missing when the queue is drained. A wake pulse that arrives together with a push shows that wake-up takes priority over the push.

// File: rtl/cmdbuf_pkg.sv
package cmdbuf_pkg;

    // Fill-level zones tracked by the level state machine.
    typedef enum logic [1:0] {
        Z_EMPTY = 2'd0,
        Z_LOW   = 2'd1,
        Z_MID   = 2'd2,
        Z_FULL  = 2'd3
    } zone_e;

    // Zone of a given byte count.
    function automatic zone_e zone_of(input int unsigned cnt,
                                      input int unsigned depth,
                                      input int unsigned low_mark);
        zone_e z;
        if (cnt == 0)
            z = Z_EMPTY;
        else if (cnt < low_mark)
            z = Z_LOW;
        else if (cnt < depth)
            z = Z_MID;
        else
            z = Z_FULL;
        return z;
    endfunction

endpackage

// File: rtl/cmdbuf_store.sv
module cmdbuf_store #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wake,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] pop_data
);

    logic [WIDTH-1:0] slots [DEPTH];
    logic [AW-1:0]    head_q;
    logic [AW-1:0]    tail_q;

    // Pointers: the head addresses the oldest byte, the tail the next free slot.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
        end else if (wake) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            if (push)
                tail_q <= (tail_q == AW'(DEPTH - 1)) ? '0 : tail_q + 1'b1;
            if (pop)
                head_q <= (head_q == AW'(DEPTH - 1)) ? '0 : head_q + 1'b1;
        end
    end

    // Storage has no reset; only written slots are ever read.
    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (push && !wake && tail_q == AW'(g))
                    slots[g] <= push_data;
            end
        end
    endgenerate

    // Output register: updates only on an accepted pop.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pop_data <= '0;
        else if (pop && !wake)
            pop_data <= slots[head_q];
    end

endmodule

// File: rtl/cmdbuf_level.sv
module cmdbuf_level
    import cmdbuf_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int LOW_MARK = DEPTH / 4,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wake,
    input  logic          push,
    input  logic          pop,
    output logic [CW-1:0] level,
    output logic          empty,
    output logic          full,
    output logic          low_evt
);

    zone_e         zone_q;
    zone_e         zone_d;
    logic [CW-1:0] level_d;

    // Next count.
    always_comb begin
        level_d = level;
        if (wake)
            level_d = '0;
        else if (push && !pop)
            level_d = level + 1'b1;
        else if (pop && !push)
            level_d = level - 1'b1;
        zone_d = zone_of(int'(level_d), DEPTH, LOW_MARK);
    end

    // State register: count and zone.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level  <= '0;
            zone_q <= Z_EMPTY;
        end else begin
            level  <= level_d;
            zone_q <= zone_d;
        end
    end

    // Outputs from the zone state.
    always_comb begin
        empty   = 1'b0;
        full    = 1'b0;
        low_evt = 1'b0;
        unique case (zone_q)
            Z_EMPTY: empty = 1'b1;
            Z_LOW:   ;
            Z_MID:   low_evt = (zone_d == Z_LOW) && !wake;
            Z_FULL:  full = 1'b1;
            default: ;
        endcase
    end

    // R3
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CW'(DEPTH));

    // R3
    empty_full_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty && full));

    // R9
    wake_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> (level == '0) && empty);

endmodule

// File: rtl/cmdbuf_irq.sv
module cmdbuf_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic wake,
    input  logic low_evt,
    input  logic ovf_evt,
    input  logic clr_low,
    input  logic clr_ovf,
    output logic low_flag,
    output logic ovf_flag,
    output logic irq
);

    // Sticky flags: an event in the same cycle as its clear keeps the flag set.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_flag <= 1'b0;
            ovf_flag <= 1'b0;
        end else if (wake) begin
            low_flag <= 1'b0;
            ovf_flag <= 1'b0;
        end else begin
            if (low_evt)
                low_flag <= 1'b1;
            else if (clr_low)
                low_flag <= 1'b0;
            if (ovf_evt)
                ovf_flag <= 1'b1;
            else if (clr_ovf)
                ovf_flag <= 1'b0;
        end
    end

    assign irq = low_flag | ovf_flag;

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !clr_ovf && !wake) |=> ovf_flag);

    // R8
    low_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (low_flag && !clr_low && !wake) |=> low_flag);

endmodule

// File: rtl/cmdbuf_fifo.sv
module cmdbuf_fifo #(
    parameter int DEPTH    = 16,
    parameter int WIDTH    = 8,
    parameter int LOW_MARK = DEPTH / 4,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wake,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic [CW-1:0]    fill_level,
    output logic             buf_empty,
    output logic             buf_full,
    input  logic             clr_low,
    input  logic             clr_ovf,
    output logic             low_flag,
    output logic             ovf_flag,
    output logic             irq
);

    logic pop_go;
    logic push_go;
    logic ovf_evt;
    logic low_evt;

    // Acceptance: a pop needs data; a push needs room or a same-cycle pop.
    assign pop_go  = rd_en && !buf_empty && !wake;
    assign push_go = wr_en && (!buf_full || pop_go) && !wake;
    assign ovf_evt = wr_en && buf_full && !pop_go && !wake;

    cmdbuf_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wake      (wake),
        .push      (push_go),
        .push_data (wr_data),
        .pop       (pop_go),
        .pop_data  (rd_data)
    );

    cmdbuf_level #(.DEPTH(DEPTH), .LOW_MARK(LOW_MARK)) i_level (
        .clk     (clk),
        .rst_n   (rst_n),
        .wake    (wake),
        .push    (push_go),
        .pop     (pop_go),
        .level   (fill_level),
        .empty   (buf_empty),
        .full    (buf_full),
        .low_evt (low_evt)
    );

    cmdbuf_irq i_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wake     (wake),
        .low_evt  (low_evt),
        .ovf_evt  (ovf_evt),
        .clr_low  (clr_low),
        .clr_ovf  (clr_ovf),
        .low_flag (low_flag),
        .ovf_flag (ovf_flag),
        .irq      (irq)
    );

    // R5
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && buf_full && !wake) |=> $stable(fill_level) && ovf_flag);

    // R7
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && buf_empty && !wake) |=> $stable(rd_data) && buf_empty);

    // R6
    low_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(low_flag) |-> (fill_level == CW'(LOW_MARK - 1)) && ($past(fill_level) == CW'(LOW_MARK)));

    // R4
    both_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_en && !buf_empty && !wake) |=> $stable(fill_level));

endmodule

// File: tb/test_cmdbuf_fifo.sv
module test_cmdbuf_fifo;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 9;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wake = 1'b0, wr_en = 1'b0, rd_en = 1'b0, clr_low = 1'b0, clr_ovf = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [4:0] fill_level;
    logic       buf_empty, buf_full, low_flag, ovf_flag, irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [7:0] model[$];
    logic [7:0] last_rd = '0;

    // Vector: {wr, rd, data[7:0], expected level[4:0], expected irq}
    localparam logic [15:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 8'hA0, 5'd1, 1'b0},
        {1'b1, 1'b0, 8'hA1, 5'd2, 1'b0},
        {1'b1, 1'b0, 8'hA2, 5'd3, 1'b0},
        {1'b1, 1'b0, 8'hA3, 5'd4, 1'b0},
        {1'b1, 1'b0, 8'hA4, 5'd5, 1'b0},
        {1'b0, 1'b1, 8'h00, 5'd4, 1'b0},
        {1'b1, 1'b1, 8'hA5, 5'd4, 1'b0},
        {1'b0, 1'b1, 8'h00, 5'd3, 1'b1},
        {1'b0, 1'b1, 8'h00, 5'd2, 1'b1}
    };

    cmdbuf_fifo i_cmdbuf_fifo (
        .clk(clk), .rst_n(rst_n), .wake(wake), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .fill_level(fill_level),
        .buf_empty(buf_empty), .buf_full(buf_full), .clr_low(clr_low),
        .clr_ovf(clr_ovf), .low_flag(low_flag), .ovf_flag(ovf_flag), .irq(irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, update the reference queue, sample at the next negedge.
    task automatic step(input logic w, input logic r, input logic [7:0] d,
                        input logic cl = 1'b0, input logic co = 1'b0, input logic wk = 1'b0);
        bit pop_ok;
        bit push_ok;
        wr_en = w; rd_en = r; wr_data = d; clr_low = cl; clr_ovf = co; wake = wk;
        pop_ok  = r && (model.size() > 0) && !wk;
        push_ok = w && ((model.size() < 16) || pop_ok) && !wk;
        if (wk) model.delete();
        if (pop_ok) last_rd = model.pop_front();
        if (push_ok) model.push_back(d);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; clr_low = 1'b0; clr_ovf = 1'b0; wake = 1'b0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                errors++;
                $display("FAIL watchdog expired");
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        // R1 reset state
        chk("R1 empty", buf_empty, 1);
        chk("R1 full", buf_full, 0);
        chk("R1 level", fill_level, 0);
        chk("R1 irq", irq, 0);
        chk("R1 rd_data", rd_data, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R2 order, R3 level, R4 simultaneous, R6 crossing
        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][15], VEC[i][14], VEC[i][13:6]);
            chk("R3 level", fill_level, VEC[i][5:1]);
            chk("R6 irq", irq, VEC[i][0]);
            if (VEC[i][14]) chk("R2 order", rd_data, last_rd);
        end

        // R8 clear low only
        step(0, 0, 0, 1'b1, 1'b0);
        chk("R8 low cleared", low_flag, 0);
        chk("R8 irq", irq, 0);
        // R6 no refire while below the mark
        step(0, 1, 0);
        chk("R6 no refire", low_flag, 0);
        chk("R2 order", rd_data, last_rd);
        step(0, 1, 0);
        chk("R3 empty", buf_empty, 1);
        // R7 pop on empty ignored
        begin
            logic [7:0] held;
            held = rd_data;
            step(0, 1, 0);
            chk("R7 rd_data hold", rd_data, held);
            chk("R7 level", fill_level, 0);
        end

        // Fill to full: R3
        for (int i = 0; i < 16; i++) step(1, 0, 8'hB0 + 8'(i));
        chk("R3 full", buf_full, 1);
        chk("R3 level16", fill_level, 16);
        // R5 overflow
        step(1, 0, 8'hEE);
        chk("R5 level", fill_level, 16);
        chk("R5 ovf", ovf_flag, 1);
        chk("R8 irq ovf", irq, 1);
        // R4 push and pop while full
        step(1, 1, 8'hCC);
        chk("R4 level", fill_level, 16);
        chk("R4 data", rd_data, 8'hB0);
        // R8 set wins over clear
        step(1, 0, 8'hDD, 1'b0, 1'b1);
        chk("R8 set wins", ovf_flag, 1);
        step(0, 0, 0, 1'b0, 1'b1);
        chk("R8 ovf cleared", ovf_flag, 0);
        chk("R8 irq low", irq, 0);
        // Drain: R2 order, R5 dropped byte absent, R6 crossing
        for (int i = 0; i < 16; i++) begin
            step(0, 1, 0);
            chk("R2 drain order", rd_data, (i < 15) ? 8'hB1 + 8'(i) : 8'hCC);
            if (fill_level == 3) chk("R6 crossing", low_flag, 1);
        end
        chk("R3 drained", buf_empty, 1);

        // R9 wake overrides a push and clears flags
        step(1, 0, 8'h11);
        step(1, 0, 8'h22);
        step(1, 0, 8'h33, 1'b0, 1'b0, 1'b1);
        chk("R9 level", fill_level, 0);
        chk("R9 empty", buf_empty, 1);
        chk("R9 irq", irq, 0);
        step(1, 0, 8'h44);
        step(0, 1, 0);
        chk("R9 head restart", rd_data, 8'h44);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule